// File: doc/BRIEF.md
# Serial Register Access Port

This block is an SPI slave that lets an external master read and write a register file of 256 byte-wide entries. The block runs entirely on its own system clock. The serial clock, the data input and the chip select are brought into that clock domain through two-flop synchronizers, and the block detects serial clock edges there. Toward the register file it has a plain bus: an address, write data with a one-cycle write strobe, and a one-cycle read strobe with combinational read data returned in the same cycle.

Each transaction opens with two header bytes. The first header byte holds the direction flag in bit 7 (1 = read, 0 = write), zeros in bits 6..1, and address bit 7 in bit 0. The second header byte holds address bits 6..0 in bits 7..1 and a burst flag in bit 0. Data bytes follow the header. A single access moves exactly one byte. A burst moves consecutive registers, and the address wraps from 0xFF to 0x00. Two static inputs select the idle level of the clock and which edge samples. The master must keep each SCK half-period at least 4 system clocks long.

The control state machine has six states. IDLE goes to HDR_A once chip select is active. HDR_A goes to HDR_B when the first header byte is complete. HDR_B goes to WRITE or READ, according to the direction flag, when the second header byte is complete. WRITE and READ go to DRAIN after their byte when the burst flag is clear, and they stay put when the flag is set. DRAIN ignores further traffic. From every state, the machine returns to IDLE when chip select goes inactive.

Top module: `spi_regport`

## Requirements
- R1: All four clock modes work: cfg_cpol gives the idle SCK level, cfg_cpha=0 samples on the leading edge, and cfg_cpha=1 samples on the trailing edge. Every byte moves MSB first in both directions.
- R2: Header byte one is {rw, 6'b0, A[7]} and header byte two is {A[6:0], burst}. An access reaches exactly the register those bits name, so A[7] selects between registers 0x00-0x7F and 0x80-0xFF.
- R3: A single write produces exactly one reg_we pulse, with reg_addr equal to the header address and reg_wdata equal to the received data byte.
- R4: A single read issues reg_re at the header address, and the register value appears on spi_miso, MSB first, during the third byte. spi_miso is 0 during both header bytes.
- R5: A burst write strobes one register per completed data byte at consecutive addresses, wrapping from 0xFF to 0x00.
- R6: A burst read returns consecutive registers, one per data byte, wrapping from 0xFF to 0x00.
- R7: After the single data byte of a non-burst access, further bytes cause no write, and on a read they shift out 0x00.
- R8: Chip select going inactive aborts the transaction. A partly received data byte is never written, and the next transaction decodes a fresh header.
- R9: spi_miso_oe is high exactly while spi_cs_n is low. spi_miso is 0 while the chip select is inactive and after reset.
- R10: reg_we and reg_re each last one system clock and are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; it oversamples SCK |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_cpol | input | 1 | Idle level of SCK |
| cfg_cpha | input | 1 | 0: sample on the leading edge; 1: sample on the trailing edge |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sck | input | 1 | Serial clock from the master |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master |
| spi_miso_oe | output | 1 | Output enable for the spi_miso pad driver |
| reg_addr | output | 8 | Register address |
| reg_wdata | output | 8 | Register write data |
| reg_we | output | 1 | One-cycle write strobe |
| reg_re | output | 1 | One-cycle read strobe |
| reg_rdata | input | 8 | Register read data, valid in the reg_re cycle |

## Verification
The assertions check on every cycle the rules that hold at any single moment. The strobes are single-cycle and mutually exclusive. The address is steady while a write strobe is high. No strobe follows an inactive chip select. MISO rests at zero while the port is deselected. Header decoding, MSB-first ordering in all four clock modes, the address wrap in both burst directions, the bytes ignored after a single access and the discarding of an aborted byte depend on whole transactions. Only the bench shows these, with its behavioural register model and its queue of expected write strobes.

// File: rtl/spi_regport_pkg.sv
package spi_regport_pkg;
    localparam int BYTE_W    = 8;
    localparam int ADDR_W    = 8;
    localparam int BIT_CNT_W = $clog2(BYTE_W);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HDR_A,
        ST_HDR_B,
        ST_WRITE,
        ST_READ,
        ST_DRAIN
    } xact_state_e;
endpackage

// File: rtl/spi_regport_sync.sv
module spi_regport_sync #(
    parameter int               WIDTH   = 3,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] chain_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain_q[i] <= RST_VAL;
        end else begin
            chain_q[0] <= async_in;
            for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
        end
    end

    assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/spi_regport_edge.sv
module spi_regport_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic cpol,
    input  logic cpha,
    input  logic cs_act,
    input  logic sck_s,
    output logic sample_stb,
    output logic shift_stb
);
    logic sck_d;
    logic lvl_now, lvl_prev, lead, trail;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sck_d <= 1'b0;
        else        sck_d <= sck_s;
    end

    // Normalise so that the leading edge is always a rise.
    assign lvl_now  = sck_s ^ cpol;
    assign lvl_prev = sck_d ^ cpol;
    assign lead     = lvl_now & ~lvl_prev;
    assign trail    = ~lvl_now & lvl_prev;

    assign sample_stb = cs_act & (cpha ? trail : lead);
    assign shift_stb  = cs_act & (cpha ? lead : trail);
endmodule

// File: rtl/spi_regport_ctrl.sv
module spi_regport_ctrl
    import spi_regport_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_act,
    input  logic              sample_stb,
    input  logic              mosi_s,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [BYTE_W-1:0] reg_wdata,
    output logic              reg_we,
    output logic              reg_re
);
    xact_state_e          state_q, state_d;
    logic [BIT_CNT_W-1:0] bit_cnt_q;
    logic [BYTE_W-2:0]    rx_sr_q;
    logic [BYTE_W-1:0]    rx_byte;
    logic                 byte_done;
    logic                 rw_q, burst_q, incr_pend_q;
    logic [ADDR_W-1:0]    addr_q;

    assign rx_byte   = {rx_sr_q, mosi_s};
    assign byte_done = sample_stb && (bit_cnt_q == BIT_CNT_W'(BYTE_W-1));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        if (!cs_act) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:  state_d = ST_HDR_A;
                ST_HDR_A: if (byte_done) state_d = ST_HDR_B;
                ST_HDR_B: if (byte_done) state_d = rw_q ? ST_READ : ST_WRITE;
                ST_WRITE: if (byte_done && !burst_q) state_d = ST_DRAIN;
                ST_READ:  if (byte_done && !burst_q) state_d = ST_DRAIN;
                ST_DRAIN: state_d = ST_DRAIN;
            endcase
        end
    end

    // Datapath and strobes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt_q   <= '0;
            rx_sr_q     <= '0;
            rw_q        <= 1'b0;
            burst_q     <= 1'b0;
            incr_pend_q <= 1'b0;
            addr_q      <= '0;
            reg_wdata   <= '0;
            reg_we      <= 1'b0;
            reg_re      <= 1'b0;
        end else begin
            reg_we <= 1'b0;
            reg_re <= 1'b0;
            if (!cs_act) begin
                bit_cnt_q   <= '0;
                incr_pend_q <= 1'b0;
            end else begin
                if (reg_we && incr_pend_q) begin
                    addr_q      <= addr_q + ADDR_W'(1);
                    incr_pend_q <= 1'b0;
                end
                if (sample_stb) begin
                    bit_cnt_q <= bit_cnt_q + BIT_CNT_W'(1);
                    rx_sr_q   <= rx_byte[BYTE_W-2:0];
                end
                if (byte_done) begin
                    case (state_q)
                        ST_HDR_A: begin
                            rw_q                <= rx_byte[BYTE_W-1];
                            addr_q[ADDR_W-1]    <= rx_byte[0];
                        end
                        ST_HDR_B: begin
                            addr_q[ADDR_W-2:0]  <= rx_byte[BYTE_W-1:1];
                            burst_q             <= rx_byte[0];
                            reg_re              <= rw_q;
                        end
                        ST_WRITE: begin
                            reg_wdata   <= rx_byte;
                            reg_we      <= 1'b1;
                            incr_pend_q <= burst_q;
                        end
                        ST_READ: begin
                            if (burst_q) begin
                                addr_q <= addr_q + ADDR_W'(1);
                                reg_re <= 1'b1;
                            end
                        end
                        default: ;
                    endcase
                end
            end
        end
    end

    assign reg_addr = addr_q;

    // R10
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_we && reg_re));
    // R10
    we_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> !reg_we);
    // R3
    we_addr_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> $stable(reg_addr));
    // R8
    abort_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |=> (!reg_we && !reg_re));
endmodule

// File: rtl/spi_regport_tx.sv
module spi_regport_tx
    import spi_regport_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_act,
    input  logic              shift_stb,
    input  logic              load,
    input  logic [BYTE_W-1:0] load_data,
    output logic              miso
);
    logic [BYTE_W-1:0] hold_q, tx_q;
    logic              pend_q, miso_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= '0;
            tx_q   <= '0;
            pend_q <= 1'b0;
            miso_q <= 1'b0;
        end else if (!cs_act) begin
            tx_q   <= '0;
            pend_q <= 1'b0;
            miso_q <= 1'b0;
        end else begin
            if (shift_stb) begin
                if (pend_q) begin
                    miso_q <= hold_q[BYTE_W-1];
                    tx_q   <= {hold_q[BYTE_W-2:0], 1'b0};
                    pend_q <= 1'b0;
                end else begin
                    miso_q <= tx_q[BYTE_W-1];
                    tx_q   <= {tx_q[BYTE_W-2:0], 1'b0};
                end
            end
            if (load) begin
                hold_q <= load_data;
                pend_q <= 1'b1;
            end
        end
    end

    assign miso = miso_q;

    // R9
    miso_rest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |=> !miso_q);
endmodule

// File: rtl/spi_regport.sv
module spi_regport
    import spi_regport_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_cpol,
    input  logic              cfg_cpha,
    input  logic              spi_cs_n,
    input  logic              spi_sck,
    input  logic              spi_mosi,
    output logic              spi_miso,
    output logic              spi_miso_oe,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [BYTE_W-1:0] reg_wdata,
    output logic              reg_we,
    output logic              reg_re,
    input  logic [BYTE_W-1:0] reg_rdata
);
    localparam int PIN_W = 3;

    logic [PIN_W-1:0] pins_s;
    logic             cs_act, sample_stb, shift_stb;

    spi_regport_sync #(
        .WIDTH  (PIN_W),
        .STAGES (SYNC_STAGES),
        .RST_VAL(3'b100)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_in({spi_cs_n, spi_mosi, spi_sck}),
        .sync_out(pins_s)
    );

    assign cs_act = ~pins_s[2];

    spi_regport_edge u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpol      (cfg_cpol),
        .cpha      (cfg_cpha),
        .cs_act    (cs_act),
        .sck_s     (pins_s[0]),
        .sample_stb(sample_stb),
        .shift_stb (shift_stb)
    );

    spi_regport_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_act    (cs_act),
        .sample_stb(sample_stb),
        .mosi_s    (pins_s[1]),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_we    (reg_we),
        .reg_re    (reg_re)
    );

    spi_regport_tx u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_act   (cs_act),
        .shift_stb(shift_stb),
        .load     (reg_re),
        .load_data(reg_rdata),
        .miso     (spi_miso)
    );

    assign spi_miso_oe = ~spi_cs_n;
endmodule

// File: tb/spi_regport_test.sv
module spi_regport_test;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n = 1'b0;
    logic cfg_cpol = 1'b0, cfg_cpha = 1'b0;
    logic spi_sck = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0;
    logic spi_miso, spi_miso_oe, reg_we, reg_re;
    logic [7:0] reg_addr, reg_wdata, reg_rdata;

    spi_regport uut (
        .clk(clk), .rst_n(rst_n), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
        .spi_cs_n(spi_cs_n), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
        .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
        .reg_re(reg_re), .reg_rdata(reg_rdata)
    );

    // Register file behind the port, and the bench's own model of it.
    logic [7:0] rf [256];
    logic [7:0] model [256];
    assign reg_rdata = rf[reg_addr];
    always @(posedge clk) if (reg_we) rf[reg_addr] <= reg_wdata;

    int compared = 0, mismatched = 0, half = 6;
    logic [15:0] exp_wr [$];
    logic [15:0] e_w;
    logic prev_we = 1'b0;
    logic [7:0] tx_buf [8];
    logic [7:0] rx_buf [8];

    task automatic check(input bit ok, input string req, input int act, input int exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Per-clock comparison against the reference model.
    always begin
        @(negedge clk);
        #2;
        if (rst_n) begin
            check(spi_miso_oe == !spi_cs_n, "R9 output enable", spi_miso_oe, !spi_cs_n);
            if (reg_we && reg_re) check(1'b0, "R10 strobes overlap", 1, 0);
            if (reg_we && prev_we) check(1'b0, "R10 write strobe longer than one clock", 1, 0);
            if (reg_we) begin
                if (exp_wr.size() == 0) begin
                    check(1'b0, "R3 unexpected write strobe", {reg_addr, reg_wdata}, 0);
                end else begin
                    e_w = exp_wr.pop_front();
                    check({reg_addr, reg_wdata} == e_w, "R3 write address/data", {reg_addr, reg_wdata}, e_w);
                end
            end
            prev_we = reg_we;
        end
    end

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic xfer(input int nbytes, input int stop_bit);
        bit aborted = 1'b0;
        @(negedge clk);
        spi_cs_n = 1'b0;
        wait_clk(half);
        for (int b = 0; b < nbytes; b++) begin
            rx_buf[b] = 8'h00;
            for (int i = 7; i >= 0; i--) begin
                if (stop_bit >= 0 && (b * 8 + 7 - i) == stop_bit) aborted = 1'b1;
                if (!aborted) begin
                    if (!cfg_cpha) begin
                        spi_mosi = tx_buf[b][i];
                        wait_clk(half);
                        spi_sck = !cfg_cpol;
                        rx_buf[b][i] = spi_miso;
                        wait_clk(half);
                        spi_sck = cfg_cpol;
                    end else begin
                        spi_sck = !cfg_cpol;
                        spi_mosi = tx_buf[b][i];
                        wait_clk(half);
                        spi_sck = cfg_cpol;
                        rx_buf[b][i] = spi_miso;
                        wait_clk(half);
                    end
                end
            end
        end
        wait_clk(half);
        spi_cs_n = 1'b1;
        wait_clk(2 * half);
    endtask

    task automatic do_write(input logic [7:0] a, input bit burst, input int n, input logic [7:0] d0);
        tx_buf[0] = {1'b0, 6'b0, a[7]};
        tx_buf[1] = {a[6:0], burst};
        for (int k = 0; k < n; k++) begin
            logic [7:0] ak = a + 8'(k);
            logic [7:0] dk = d0 + 8'(k * 37);
            tx_buf[2 + k] = dk;
            if (burst || k == 0) begin
                exp_wr.push_back({ak, dk});
                model[ak] = dk;
            end
        end
        xfer(2 + n, -1);
    endtask

    task automatic do_read(input logic [7:0] a, input bit burst, input int n, input string req);
        tx_buf[0] = {1'b1, 6'b0, a[7]};
        tx_buf[1] = {a[6:0], burst};
        for (int k = 0; k < n; k++) tx_buf[2 + k] = 8'h00;
        xfer(2 + n, -1);
        check(rx_buf[0] == 8'h00 && rx_buf[1] == 8'h00, "R4 MISO low during header",
              {rx_buf[0], rx_buf[1]}, 0);
        for (int k = 0; k < n; k++) begin
            logic [7:0] ak = a + 8'(k);
            logic [7:0] ex = (burst || k == 0) ? model[ak] : 8'h00;
            check(rx_buf[2 + k] == ex, req, rx_buf[2 + k], ex);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "watchdog (all requirements) timeout", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) begin
            rf[i]    = 8'(i * 5 + 1);
            model[i] = 8'(i * 5 + 1);
        end
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(3);
        // Reset state (R9, R10)
        check(spi_miso_oe == 1'b0, "R9 reset output enable", spi_miso_oe, 0);
        check(spi_miso == 1'b0, "R9 reset MISO level", spi_miso, 0);
        check(!reg_we && !reg_re, "R10 reset strobes", {reg_we, reg_re}, 0);

        for (int m = 0; m < 4; m++) begin
            logic [7:0] a;
            a = (m == 0) ? 8'h21 : (m == 1) ? 8'hA5 : (m == 2) ? 8'h3C : 8'hC3;
            cfg_cpol = m[1];
            cfg_cpha = m[0];
            spi_sck  = cfg_cpol;
            half     = (m == 2) ? 4 : 6;
            wait_clk(10);
            // R1 / R3: single write in this clock mode
            do_write(a, 1'b0, 1, 8'h5A ^ 8'(m * 17));
            // R1 / R4: single read back
            do_read(a, 1'b0, 1, "R1 R4 single read in this mode");
            // R2: the other half of the map selected by A[7] is untouched
            do_read(a ^ 8'h80, 1'b0, 1, "R2 address bit 7 decode");
        end

        cfg_cpol = 1'b0;
        cfg_cpha = 1'b0;
        spi_sck  = 1'b0;
        half     = 6;
        wait_clk(10);

        // R5: burst write across the wrap
        do_write(8'hFE, 1'b1, 3, 8'h90);
        // R6: burst read across the wrap
        do_read(8'hFD, 1'b1, 5, "R6 burst read with wrap");

        // R7: extra byte after a single write is ignored
        do_write(8'h40, 1'b0, 2, 8'h11);
        do_read(8'h41, 1'b0, 1, "R7 neighbour unchanged after ignored byte");
        // R7: extra byte after a single read returns zero
        do_read(8'h40, 1'b0, 2, "R7 single read then zero");

        // R8: abort inside a data byte, four bits in
        tx_buf[0] = 8'h00;
        tx_buf[1] = {7'h50, 1'b0};
        tx_buf[2] = 8'hEE;
        xfer(3, 20);
        check(exp_wr.size() == 0, "R8 no write after abort", exp_wr.size(), 0);
        do_read(8'h50, 1'b0, 1, "R8 aborted byte discarded");
        // R8: abort inside the header, then a fresh transaction decodes
        tx_buf[0] = 8'h81;
        xfer(2, 5);
        do_write(8'h66, 1'b0, 1, 8'hC7);
        do_read(8'h66, 1'b0, 1, "R8 fresh header after abort");

        wait_clk(10);
        check(exp_wr.size() == 0, "R3 R5 all expected writes seen", exp_wr.size(), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule